// File: doc/BRIEF.md
# Set-Associative Branch Target Cache

This block is a small set-associative cache that the fetch stage consults every cycle with the address it is about to fetch. Each way of a set holds a valid flag, the upper address bits of a known branch as a tag, the address that branch last jumped to, and a 2-bit saturating direction counter. When the fetch address matches a resident branch whose counter leans towards taken, the block tells fetch to redirect and supplies the stored target. In every other case the next fetch address is the sequential one.

After a branch resolves further down the pipeline, an update port reports its address, its outcome and its real target. A resident branch has its counter trained, its target refreshed when it was taken, and its way marked most recently used. A taken branch that is not resident gets a new line: an empty way if the set has one, otherwise the way that a binary-tree pseudo-LRU scheme names. Not-taken branches that are not resident are dropped. A flush input empties the whole cache.

Top module: `branch_target_cache`

## Requirements
- R1: After a synchronous active-low reset, every way is invalid: each lookup reports no hit, no redirect, and `lk_next_pc` equals `lk_pc + 2**OFFSET_W`.
- R2: A lookup hits only when a valid way in the set selected by `lk_pc[OFFSET_W +: IDX_W]` holds the tag `lk_pc[PC_W-1 -: TAG_W]`. At most one way hits. `lk_redirect` is set when the lookup hits and bit 1 of that way's counter is 1. `lk_next_pc` is the stored target when `lk_redirect` is set and the sequential address otherwise.
- R3: A taken update that misses allocates a line holding the tag and target, with its counter at 2 (weakly taken). A lookup of that address in the next cycle redirects to the target.
- R4: A not-taken update that misses changes nothing. A later lookup of that address still misses.
- R5: An update that hits trains the counter, which counts 0 to 3. A taken outcome adds one, saturating at 3. A not-taken outcome subtracts one, saturating at 0.
- R6: A taken update that hits replaces the stored target with `upd_target`. A not-taken update leaves the target unchanged.
- R7: Allocation into a set with an empty way uses the lowest-numbered empty way and leaves the other ways unchanged.
- R8: Allocation into a full set replaces the pseudo-LRU victim. The tree has node 1 as its root, and the children of node n are 2n and 2n+1. A node bit of 0 sends the victim search to the lower-numbered half. Every write, whether it allocates or hits, sets each node on that way's path to point away from it. With 4 ways, filling ways 0..3 in order and then allocating twice evicts way 0 and then way 2. If way 0 is refreshed before the first allocation, that allocation evicts way 2 instead.
- R9: While `flush` is high, all ways become invalid at the clock edge, and a simultaneous update is discarded.
- R10: Sets are independent: allocations and evictions in one set leave the entries of other sets unchanged.
- R11: An update takes effect at the clock edge. A lookup of the same address in the same cycle sees the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate every way at the next edge |
| lk_pc | input | PC_W | Fetch address being looked up |
| lk_hit | output | 1 | Lookup matched a valid way |
| lk_redirect | output | 1 | Hit whose counter predicts taken |
| lk_next_pc | output | PC_W | Predicted target, or the sequential address |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 means taken |
| upd_target | input | PC_W | Resolved target address |

## Verification
The hardest situation to reach from the ports is a full set whose replacement choice depends on the order of earlier writes, including refreshes of resident lines. Lookups never show the tree state, so it can only be seen through which tag disappears. The bench therefore fills every way of a chosen set with distinct tags in a fixed order, optionally refreshes one of them, and then allocates new tags one at a time. After each allocation it looks up every tag in that set and in its neighbours, so each eviction and the untouched sets are both confirmed. Counter training is swept through both saturation points by a fixed outcome string, with the expected counter computed arithmetically beside it.

// File: rtl/btc_pkg.sv
// Shared types and the direction-counter training rule for the branch target cache.
// Assumes a 2-bit counter where bit 1 is the taken prediction.
package btc_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_TAKEN = 2'd2;

    // Saturating step of a 2-bit counter towards the resolved outcome.
    function automatic ctr_t ctr_train(ctr_t cur, logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken && cur != 2'd3) begin
            nxt = cur + 2'd1;
        end else if (!taken && cur != 2'd0) begin
            nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/btc_way_match.sv
// Compares one tag against every way of a set.
// Assumes the allocation policy keeps tags unique within a set, so at most one way matches.
module btc_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 23,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            tag,
    output logic [WAYS-1:0]             hit_vec,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid[w] && (tags[w] == tag);
    end

    // Encode the matching way; the lowest index wins if the invariant were ever broken.
    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/btc_plru.sv
// Binary-tree pseudo-LRU for one set: names a victim and computes the tree after a touch.
// Assumes WAYS is a power of two, at least 2. Node n (root 1) is stored at bit n-1,
// and a bit of 0 means the victim lies in the lower-numbered half.
module btc_plru #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-2:0]  tree,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim,
    output logic [WAYS-2:0]  tree_touched
);

    // Walk from the root following the node bits to the least recently used leaf.
    always_comb begin
        int node;
        node = 1;
        for (int l = 0; l < WAY_W; l++) begin
            node = node * 2 + (tree[node-1] ? 1 : 0);
        end
        victim = WAY_W'(node - WAYS);
    end

    // Point every node on the touched way's path away from that way.
    always_comb begin
        int  node;
        logic dir;
        tree_touched = tree;
        node = 1;
        for (int l = 0; l < WAY_W; l++) begin
            dir = touch_way[WAY_W-1-l];
            tree_touched[node-1] = ~dir;
            node = node * 2 + (dir ? 1 : 0);
        end
    end

endmodule

// File: rtl/branch_target_cache.sv
// Set-associative branch target cache: combinational lookup at fetch, registered update
// after resolve. Assumes one update per cycle, word-aligned fetch addresses
// (OFFSET_W low bits ignored), and that lookups do not change replacement state.
module branch_target_cache #(
    parameter int PC_W     = 32,
    parameter int SETS     = 128,
    parameter int WAYS     = 4,
    parameter int OFFSET_W = 2,
    localparam int IDX_W   = $clog2(SETS),
    localparam int TAG_W   = PC_W - OFFSET_W - IDX_W,
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_redirect,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    import btc_pkg::*;

    localparam logic [PC_W-1:0] STEP = PC_W'(1) << OFFSET_W;

    // Storage, one entry per set and way.
    logic [SETS-1:0][WAYS-1:0]             valid_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [SETS-1:0][WAYS-1:0][PC_W-1:0]   tgt_q;
    logic [SETS-1:0][WAYS-1:0][1:0]        ctr_q;
    logic [SETS-1:0][WAYS-2:0]             plru_q;

    // ---------------- lookup path ----------------
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  lk_hit_vec;
    logic [WAY_W-1:0] lk_way;
    ctr_t             lk_ctr;

    assign lk_idx = lk_pc[OFFSET_W +: IDX_W];
    assign lk_tag = lk_pc[PC_W-1 -: TAG_W];

    btc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .valid   (valid_q[lk_idx]),
        .tags    (tag_q[lk_idx]),
        .tag     (lk_tag),
        .hit_vec (lk_hit_vec),
        .hit     (lk_hit),
        .hit_way (lk_way)
    );

    // Choose between the stored target and the fall-through address.
    always_comb begin
        lk_ctr      = ctr_q[lk_idx][lk_way];
        lk_redirect = lk_hit && lk_ctr[1];
        lk_next_pc  = lk_redirect ? tgt_q[lk_idx][lk_way] : lk_pc + STEP;
    end

    // ---------------- update path ----------------
    logic [IDX_W-1:0] up_idx;
    logic [TAG_W-1:0] up_tag;
    logic [WAYS-1:0]  up_hit_vec;
    logic             up_hit;
    logic [WAY_W-1:0] up_hit_way;
    logic [WAY_W-1:0] plru_victim;
    logic [WAY_W-1:0] free_way;
    logic             any_free;
    logic [WAY_W-1:0] wr_way;
    logic             do_write;
    logic [WAYS-2:0]  plru_next;
    logic [WAYS-1:0]  up_set_valid;

    assign up_idx       = upd_pc[OFFSET_W +: IDX_W];
    assign up_tag       = upd_pc[PC_W-1 -: TAG_W];
    assign up_set_valid = valid_q[up_idx];

    btc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
        .valid   (up_set_valid),
        .tags    (tag_q[up_idx]),
        .tag     (up_tag),
        .hit_vec (up_hit_vec),
        .hit     (up_hit),
        .hit_way (up_hit_way)
    );

    btc_plru #(.WAYS(WAYS)) u_plru (
        .tree         (plru_q[up_idx]),
        .touch_way    (wr_way),
        .victim       (plru_victim),
        .tree_touched (plru_next)
    );

    // Find the lowest-numbered empty way of the updated set.
    always_comb begin
        any_free = ~&up_set_valid;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!up_set_valid[w]) begin
                free_way = WAY_W'(w);
            end
        end
    end

    // Pick the way to write and decide whether the update writes at all.
    always_comb begin
        if (up_hit) begin
            wr_way = up_hit_way;
        end else if (any_free) begin
            wr_way = free_way;
        end else begin
            wr_way = plru_victim;
        end
        do_write = upd_valid && !flush && (up_hit || upd_taken);
    end

    // Valid flags and replacement trees: cleared by reset and flush, set on write.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
            plru_q  <= '0;
        end else if (do_write) begin
            valid_q[up_idx][wr_way] <= 1'b1;
            plru_q[up_idx]          <= plru_next;
        end
    end

    // Entry payload: tag, target and counter, written on allocation or training.
    always_ff @(posedge clk) begin
        if (do_write) begin
            tag_q[up_idx][wr_way] <= up_tag;
            if (upd_taken) begin
                tgt_q[up_idx][wr_way] <= upd_target;
            end
            if (up_hit) begin
                ctr_q[up_idx][wr_way] <= ctr_train(ctr_q[up_idx][wr_way], upd_taken);
            end else begin
                ctr_q[up_idx][wr_way] <= CTR_WEAK_TAKEN;
            end
        end
    end

    // ---------------- assertions ----------------
    logic             chk_alloc;
    logic [IDX_W-1:0] chk_idx;
    logic [TAG_W-1:0] chk_tag;
    logic             chk_seen;

    // Remember the last taken update so its residency can be checked a cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_alloc <= 1'b0;
            chk_idx   <= '0;
            chk_tag   <= '0;
        end else begin
            chk_alloc <= upd_valid && upd_taken && !flush;
            chk_idx   <= up_idx;
            chk_tag   <= up_tag;
        end
    end

    // Search the remembered set for the remembered tag.
    always_comb begin
        chk_seen = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_q[chk_idx][w] && tag_q[chk_idx][w] == chk_tag) begin
                chk_seen = 1'b1;
            end
        end
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec)); // R2

    AST_TAKEN_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        chk_alloc |-> chk_seen); // R3

    AST_NT_MISS_NOALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && !up_hit && !flush) |=> $stable(valid_q)); // R4

    AST_ALLOC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && !up_hit && any_free && !flush)
        |=> $countones(valid_q[$past(up_idx)]) == $countones($past(up_set_valid)) + 1); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0)); // R9

endmodule

// File: tb/branch_target_cache_bench.sv
// Self-checking bench on a small configuration: 4 sets, 4 ways, 16-bit addresses.
module branch_target_cache_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 16;
    localparam int SETS = 4;
    localparam int WAYS = 4;
    localparam int OFF  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flush = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_hit;
    logic            lk_redirect;
    logic [PC_W-1:0] lk_next_pc;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic [PC_W-1:0] upd_target = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    branch_target_cache #(.PC_W(PC_W), .SETS(SETS), .WAYS(WAYS), .OFFSET_W(OFF)) u_branch_target_cache (
        .clk, .rst_n, .flush, .lk_pc, .lk_hit, .lk_redirect, .lk_next_pc,
        .upd_valid, .upd_pc, .upd_taken, .upd_target
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Address with tag in [15:4], set in [3:2], zero offset.
    function automatic logic [PC_W-1:0] mk(int set, int tag);
        return {tag[11:0], set[1:0], 2'b00};
    endfunction

    function automatic logic [PC_W-1:0] tgt_of(int set, int tag, int salt);
        return PC_W'(16'h8000 + set * 16'h0100 + tag * 16'h0010 + salt * 4);
    endfunction

    // Look up pc after the falling edge and compare all three outputs.
    task automatic look(string req, logic [PC_W-1:0] pc, logic eh, logic er, logic [PC_W-1:0] en);
        @(negedge clk);
        lk_pc = pc;
        #1;
        checks++;
        if (lk_hit !== eh || lk_redirect !== er || lk_next_pc !== en) begin
            errors++;
            $display("FAIL %s pc=%h got hit=%b redir=%b next=%h expected hit=%b redir=%b next=%h",
                     req, pc, lk_hit, lk_redirect, lk_next_pc, eh, er, en);
        end
    endtask

    task automatic upd(logic [PC_W-1:0] pc, logic tk, logic [PC_W-1:0] tg);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic expect_hit(string req, int set, int tag, int salt);
        look(req, mk(set, tag), 1'b1, 1'b1, tgt_of(set, tag, salt));
    endtask

    task automatic expect_miss(string req, int set, int tag);
        look(req, mk(set, tag), 1'b0, 1'b0, mk(set, tag) + 16'd4);
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c;
        bit outcomes [9] = '{0, 0, 0, 1, 1, 1, 1, 0, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything misses after reset, in every set.
        for (int s = 0; s < SETS; s++) begin
            for (int t = 0; t < 3; t++) begin
                expect_miss("R1", s, t * 5 + 1);
            end
        end

        // R4: a not-taken branch that misses is not inserted.
        upd(mk(0, 7), 1'b0, tgt_of(0, 7, 0));
        expect_miss("R4", 0, 7);

        // R11: the lookup in the update's own cycle sees the old contents.
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = mk(0, 9); upd_taken = 1'b1; upd_target = tgt_of(0, 9, 0);
        lk_pc = mk(0, 9);
        #1;
        checks++;
        if (lk_hit !== 1'b0) begin
            errors++;
            $display("FAIL R11 got hit=%b expected hit=0", lk_hit);
        end
        @(negedge clk);
        upd_valid = 1'b0;
        // R3: allocated at weakly taken, so it redirects at once.
        expect_hit("R3", 0, 9, 0);

        // R3: one taken allocation in each other set.
        for (int s = 1; s < SETS; s++) begin
            upd(mk(s, 9), 1'b1, tgt_of(s, 9, 0));
            expect_hit("R3", s, 9, 0);
        end

        // R5: sweep the counter through both saturation points.
        c = 2;
        foreach (outcomes[i]) begin
            upd(mk(0, 9), outcomes[i], tgt_of(0, 9, 0));
            if (outcomes[i]) c = (c == 3) ? 3 : c + 1;
            else             c = (c == 0) ? 0 : c - 1;
            look("R5", mk(0, 9), 1'b1, c >= 2, (c >= 2) ? tgt_of(0, 9, 0) : mk(0, 9) + 16'd4);
        end
        // counter is now 1; two taken updates bring it to 3.
        upd(mk(0, 9), 1'b1, tgt_of(0, 9, 0));
        upd(mk(0, 9), 1'b1, tgt_of(0, 9, 0));

        // R6: a taken hit rewrites the target; a not-taken hit keeps it.
        upd(mk(0, 9), 1'b1, tgt_of(0, 9, 3));
        expect_hit("R6", 0, 9, 3);
        upd(mk(0, 9), 1'b0, tgt_of(0, 9, 5));
        expect_hit("R6", 0, 9, 3);

        // R7/R8: set 1 already holds tag 9 in way 0; fill ways 1..3 with tags 1..3.
        for (int t = 1; t <= 3; t++) begin
            upd(mk(1, t), 1'b1, tgt_of(1, t, 0));
            expect_hit("R7", 1, t, 0);
        end
        expect_hit("R7", 1, 9, 0);
        // Full set: next allocation evicts way 0 (tag 9), the one after evicts way 2 (tag 2).
        upd(mk(1, 20), 1'b1, tgt_of(1, 20, 0));
        expect_miss("R8", 1, 9);
        expect_hit("R8", 1, 1, 0);
        expect_hit("R8", 1, 2, 0);
        expect_hit("R8", 1, 3, 0);
        expect_hit("R8", 1, 20, 0);
        upd(mk(1, 21), 1'b1, tgt_of(1, 21, 0));
        expect_miss("R8", 1, 2);
        expect_hit("R8", 1, 1, 0);
        expect_hit("R8", 1, 3, 0);
        expect_hit("R8", 1, 20, 0);
        expect_hit("R8", 1, 21, 0);

        // R8: set 2 filled in order, then way 0 refreshed, so the victim is way 2.
        for (int t = 1; t <= 3; t++) begin
            upd(mk(2, t), 1'b1, tgt_of(2, t, 0));
        end
        upd(mk(2, 9), 1'b1, tgt_of(2, 9, 0));
        upd(mk(2, 30), 1'b1, tgt_of(2, 30, 0));
        expect_hit("R8", 2, 9, 0);
        expect_miss("R8", 2, 2);
        expect_hit("R8", 2, 1, 0);
        expect_hit("R8", 2, 3, 0);

        // R10: other sets are untouched by the evictions above.
        expect_hit("R10", 3, 9, 0);
        expect_hit("R10", 0, 9, 3);

        // R9: flush with a simultaneous taken update leaves nothing resident.
        @(negedge clk);
        flush = 1'b1;
        upd_valid = 1'b1; upd_pc = mk(3, 40); upd_taken = 1'b1; upd_target = tgt_of(3, 40, 0);
        @(negedge clk);
        flush = 1'b0; upd_valid = 1'b0;
        expect_miss("R9", 3, 40);
        for (int s = 0; s < SETS; s++) begin
            expect_miss("R9", s, 9);
        end
        expect_miss("R9", 1, 20);

        // R7: after flush a new allocation lands and hits again.
        upd(mk(3, 41), 1'b1, tgt_of(3, 41, 0));
        expect_hit("R7", 3, 41, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule